// File: doc/BRIEF.md
# Diverse Processing-Element Allocator

This block hands out a small pool of identical processing elements to traces arriving from two threads: a leading (active) stream and a trailing (redundant) copy of the same program. Each element runs at most one trace at a time. A leading-stream trace may be placed on any element that is both idle and healthy. A trailing-stream trace arrives with the index of the element that ran its leading copy. It must go to some other element, so that one faulty element cannot corrupt both copies in the same way.

Each cycle, the dispatch logic raises one or both request lines. The allocator answers in the same cycle. The answer is a one-hot grant vector, the encoded element index, and a bit that says which thread won. At most one trace is placed per cycle.

The allocator also accepts two other inputs:
- Retirement notices, which return an element to the free pool.
- Removal commands, which take an element out of service for good after a permanent fault is found.

Top module: `pe_allocator`

## Requirements
- R1: After reset, no element is busy, no element is disabled, and no grant is issued while no request is raised.
- R2: A leading-stream request (act_req) with no competing trailing grant receives the lowest-numbered element that is neither busy nor disabled. grant_thread is 0, grant_onehot has exactly that bit set, and grant_id is its index.
- R3: A trailing-stream grant (grant_thread 1) never names the element given on red_excl_id. It is always the lowest-numbered idle, healthy element other than that one.
- R4: When the only idle, healthy element is the excluded one, the trailing request gets no grant. If act_req is raised in the same cycle, the leading stream is granted that element.
- R5: When both requests are raised and the trailing request can be placed, the trailing request wins. At most one grant is issued per cycle.
- R6: A granted element shows as busy in busy_mask from the next cycle. It is not granted again until it is released.
- R7: A release (rel_valid with rel_id) of a busy element makes it idle from the next cycle, and rel_err stays low.
- R8: A release naming an element that is not busy raises rel_err in that same cycle and leaves busy_mask unchanged.
- R9: A removal command (dis_valid with dis_id) sets the element's bit in disabled_mask from the next cycle, for good. A disabled element is never granted again, even after its current trace is released.
- R10: When no element qualifies for any raised request, grant_valid is 0 and grant_onehot is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_req | input | 1 | Leading-stream trace waiting for an element |
| red_req | input | 1 | Trailing-stream trace waiting for an element |
| red_excl_id | input | IDW | Element that ran the leading copy of the trailing trace |
| grant_valid | output | 1 | An element is granted this cycle |
| grant_thread | output | 1 | Winner of the grant: 0 leading, 1 trailing |
| grant_onehot | output | NUM_PE | One-hot vector of the granted element |
| grant_id | output | IDW | Index of the granted element |
| rel_valid | input | 1 | A trace retires from element rel_id |
| rel_id | input | IDW | Element being released |
| rel_err | output | 1 | The release names an element that is not busy |
| dis_valid | input | 1 | Remove element dis_id from service permanently |
| dis_id | input | IDW | Element being removed |
| busy_mask | output | NUM_PE | Elements currently holding a trace |
| disabled_mask | output | NUM_PE | Elements removed from service |

## Verification
The hardest situation to reach is the blocked trailing trace: the excluded element must be the only idle one. The stimulus first fills the pool with leading and trailing grants until exactly one element remains free. It then asks for a trailing placement excluded from that element, alone and then together with a leading request, so the lone element goes to the leading stream. A second hard case is removing an element while it is still busy. The bench disables it mid-trace, releases it, and then confirms that a later request still passes it over.

// File: rtl/pe_alloc_pkg.sv
package pe_alloc_pkg;

  typedef enum logic {
    THR_ACTIVE = 1'b0,
    THR_REDUN  = 1'b1
  } thread_e;

endpackage

// File: rtl/pe_pick.sv
module pe_pick #(
  parameter int NUM_PE = 4,
  parameter int IDW    = $clog2(NUM_PE)
) (
  input  logic [NUM_PE-1:0] cand,
  output logic              found,
  output logic [NUM_PE-1:0] pick_oh,
  output logic [IDW-1:0]    pick_idx
);

  function automatic logic [NUM_PE-1:0] lowest_set(input logic [NUM_PE-1:0] v);
    logic [NUM_PE-1:0] r;
    r = '0;
    for (int i = NUM_PE - 1; i >= 0; i--) begin
      if (v[i]) r = '0;
      if (v[i]) r[i] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [IDW-1:0] oh_to_idx(input logic [NUM_PE-1:0] oh);
    logic [IDW-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_PE; i++) begin
      if (oh[i]) r = r | IDW'(i);
    end
    return r;
  endfunction

  always_comb begin
    pick_oh  = lowest_set(cand);
    pick_idx = oh_to_idx(pick_oh);
    found    = |cand;
  end

endmodule

// File: rtl/pe_status_table.sv
module pe_status_table #(
  parameter int NUM_PE = 4,
  parameter int IDW    = $clog2(NUM_PE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_PE-1:0] set_mask,
  input  logic              rel_valid,
  input  logic [IDW-1:0]    rel_id,
  input  logic              dis_valid,
  input  logic [IDW-1:0]    dis_id,
  output logic [NUM_PE-1:0] busy_q,
  output logic [NUM_PE-1:0] dis_q,
  output logic              rel_err
);

  logic [NUM_PE-1:0] rel_hit;
  logic [NUM_PE-1:0] dis_hit;

  assign rel_err = rel_valid && !busy_q[rel_id];

  for (genvar g = 0; g < NUM_PE; g++) begin : g_elem
    assign rel_hit[g] = rel_valid && (rel_id == IDW'(g)) && busy_q[g];
    assign dis_hit[g] = dis_valid && (dis_id == IDW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_q[g] <= 1'b0;
        dis_q[g]  <= 1'b0;
      end else begin
        busy_q[g] <= (busy_q[g] & ~rel_hit[g]) | set_mask[g];
        dis_q[g]  <= dis_q[g] | dis_hit[g];
      end
    end
  end

  // R7
  rel_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && !rel_err) |=> !busy_q[$past(rel_id)]);

  // R8
  bad_rel_noeffect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_err |=> busy_q == ($past(busy_q) | $past(set_mask)));

  // R9
  dis_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_q & ~$past(dis_q)) == (dis_q & ~$past(dis_q)) && ((dis_q & $past(dis_q)) == $past(dis_q)));

endmodule

// File: rtl/pe_allocator.sv
module pe_allocator #(
  parameter int NUM_PE = 4,
  parameter int IDW    = $clog2(NUM_PE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_req,
  input  logic              red_req,
  input  logic [IDW-1:0]    red_excl_id,
  output logic              grant_valid,
  output logic              grant_thread,
  output logic [NUM_PE-1:0] grant_onehot,
  output logic [IDW-1:0]    grant_id,
  input  logic              rel_valid,
  input  logic [IDW-1:0]    rel_id,
  output logic              rel_err,
  input  logic              dis_valid,
  input  logic [IDW-1:0]    dis_id,
  output logic [NUM_PE-1:0] busy_mask,
  output logic [NUM_PE-1:0] disabled_mask
);
  import pe_alloc_pkg::*;

  function automatic logic [NUM_PE-1:0] idx_to_oh(input logic [IDW-1:0] idx);
    logic [NUM_PE-1:0] r;
    r = '0;
    r[idx] = 1'b1;
    return r;
  endfunction

  logic [NUM_PE-1:0] eligible;
  logic [NUM_PE-1:0] red_cand;
  logic              act_found, red_found;
  logic [NUM_PE-1:0] act_oh, red_oh;
  logic [IDW-1:0]    act_idx, red_idx;
  logic              red_win, act_win;
  thread_e           win_thr;

  assign eligible = ~busy_mask & ~disabled_mask;
  assign red_cand = eligible & ~idx_to_oh(red_excl_id);

  pe_pick #(.NUM_PE(NUM_PE), .IDW(IDW)) u_act_pick (
    .cand(eligible), .found(act_found), .pick_oh(act_oh), .pick_idx(act_idx)
  );

  pe_pick #(.NUM_PE(NUM_PE), .IDW(IDW)) u_red_pick (
    .cand(red_cand), .found(red_found), .pick_oh(red_oh), .pick_idx(red_idx)
  );

  assign red_win = red_req && red_found;
  assign act_win = act_req && act_found && !red_win;
  assign win_thr = red_win ? THR_REDUN : THR_ACTIVE;

  always_comb begin
    grant_valid  = red_win || act_win;
    grant_thread = logic'(win_thr);
    grant_onehot = '0;
    grant_id     = '0;
    if (red_win) begin
      grant_onehot = red_oh;
      grant_id     = red_idx;
    end else if (act_win) begin
      grant_onehot = act_oh;
      grant_id     = act_idx;
    end
  end

  pe_status_table #(.NUM_PE(NUM_PE), .IDW(IDW)) u_table (
    .clk(clk), .rst_n(rst_n), .set_mask(grant_onehot),
    .rel_valid(rel_valid), .rel_id(rel_id),
    .dis_valid(dis_valid), .dis_id(dis_id),
    .busy_q(busy_mask), .dis_q(disabled_mask), .rel_err(rel_err)
  );

  // R5
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_onehot) && (grant_valid == (grant_onehot != '0)));

  // R3
  excl_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && grant_thread) |-> (grant_id != red_excl_id));

  // R6
  no_double_book_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_onehot & busy_mask) == '0);

  // R6
  grant_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |=> busy_mask[$past(grant_id)]);

  // R9
  no_disabled_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_onehot & disabled_mask) == '0);

  // R4
  blocked_lends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (red_req && !red_found && act_req && act_found) |-> (grant_valid && !grant_thread));

endmodule

// File: tb/sim_pe_allocator.sv
module sim_pe_allocator;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       act_req = 1'b0, red_req = 1'b0;
  logic [1:0] red_excl_id = '0;
  logic       grant_valid, grant_thread;
  logic [3:0] grant_onehot;
  logic [1:0] grant_id;
  logic       rel_valid = 1'b0;
  logic [1:0] rel_id = '0;
  logic       rel_err;
  logic       dis_valid = 1'b0;
  logic [1:0] dis_id = '0;
  logic [3:0] busy_mask, disabled_mask;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pe_allocator #(.NUM_PE(4)) u0 (
    .clk(clk), .rst_n(rst_n), .act_req(act_req), .red_req(red_req),
    .red_excl_id(red_excl_id), .grant_valid(grant_valid),
    .grant_thread(grant_thread), .grant_onehot(grant_onehot),
    .grant_id(grant_id), .rel_valid(rel_valid), .rel_id(rel_id),
    .rel_err(rel_err), .dis_valid(dis_valid), .dis_id(dis_id),
    .busy_mask(busy_mask), .disabled_mask(disabled_mask)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input bit a, input bit r, input int excl,
                       input bit rv, input int rid, input bit dv, input int did);
    @(negedge clk);
    act_req = a; red_req = r; red_excl_id = 2'(excl);
    rel_valid = rv; rel_id = 2'(rid); dis_valid = dv; dis_id = 2'(did);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    act_req = 0; red_req = 0; rel_valid = 0; dis_valid = 0;
    #1;
  endtask

  task automatic expect_grant(input string req, input bit v, input int thr, input int id);
    check(req, "grant_valid", grant_valid, v);
    if (v) begin
      check(req, "grant_thread", grant_thread, thr);
      check(req, "grant_id", grant_id, id);
      check(req, "grant_onehot", grant_onehot, 1 << id);
    end else begin
      check(req, "grant_onehot", grant_onehot, 0);
    end
  endtask

  task automatic t_reset();
    #1;
    check("R1", "busy_mask", busy_mask, 0);
    check("R1", "disabled_mask", disabled_mask, 0);
    check("R1", "grant_valid", grant_valid, 0);
  endtask

  task automatic t_active();
    drive(1, 0, 0, 0, 0, 0, 0);
    expect_grant("R2", 1, 0, 0);
    idle();
    check("R6", "busy after first grant", busy_mask, 4'b0001);
    drive(1, 0, 0, 0, 0, 0, 0);
    expect_grant("R2", 1, 0, 1);
    idle();
    check("R6", "busy after second grant", busy_mask, 4'b0011);
  endtask

  task automatic t_redundant();
    drive(0, 1, 2, 0, 0, 0, 0);
    expect_grant("R3", 1, 1, 3);
    idle();
    check("R6", "busy after trailing grant", busy_mask, 4'b1011);
  endtask

  task automatic t_blocked();
    drive(0, 1, 2, 0, 0, 0, 0);
    expect_grant("R4", 0, 0, 0);
    idle();
    check("R4", "busy unchanged while blocked", busy_mask, 4'b1011);
    drive(1, 1, 2, 0, 0, 0, 0);
    expect_grant("R4", 1, 0, 2);
    idle();
    check("R6", "pool full", busy_mask, 4'b1111);
    drive(1, 1, 0, 0, 0, 0, 0);
    expect_grant("R10", 0, 0, 0);
    idle();
  endtask

  task automatic t_release();
    drive(0, 0, 0, 1, 0, 0, 0);
    check("R7", "rel_err on good release", rel_err, 0);
    idle();
    check("R7", "busy after release", busy_mask, 4'b1110);
    drive(0, 0, 0, 1, 0, 0, 0);
    check("R8", "rel_err on idle element", rel_err, 1);
    idle();
    check("R8", "busy unchanged after bad release", busy_mask, 4'b1110);
  endtask

  task automatic t_priority();
    drive(1, 1, 3, 0, 0, 0, 0);
    expect_grant("R5", 1, 1, 0);
    idle();
    check("R5", "busy after trailing win", busy_mask, 4'b1111);
    drive(0, 0, 0, 1, 1, 0, 0);
    idle();
    drive(0, 0, 0, 1, 2, 0, 0);
    idle();
    check("R7", "two releases", busy_mask, 4'b1001);
    drive(1, 1, 1, 0, 0, 0, 0);
    expect_grant("R5", 1, 1, 2);
    idle();
    drive(1, 0, 0, 0, 0, 0, 0);
    expect_grant("R2", 1, 0, 1);
    idle();
    check("R6", "pool full again", busy_mask, 4'b1111);
  endtask

  task automatic t_disable();
    drive(0, 0, 0, 1, 0, 0, 0);
    idle();
    drive(0, 0, 0, 0, 0, 1, 0);
    idle();
    check("R9", "disabled_mask", disabled_mask, 4'b0001);
    drive(1, 0, 0, 0, 0, 0, 0);
    expect_grant("R9", 0, 0, 0);
    idle();
    drive(0, 0, 0, 1, 3, 0, 0);
    idle();
    drive(1, 0, 0, 0, 0, 0, 0);
    expect_grant("R9", 1, 0, 3);
    idle();
    drive(0, 0, 0, 0, 0, 1, 1);
    idle();
    drive(0, 0, 0, 1, 1, 0, 0);
    check("R7", "rel_err on disabled busy element", rel_err, 0);
    idle();
    check("R9", "disabled_mask two", disabled_mask, 4'b0011);
    check("R9", "busy after release of disabled", busy_mask, 4'b1100);
    drive(1, 1, 2, 0, 0, 0, 0);
    expect_grant("R9", 0, 0, 0);
    idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #20000000;
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_active();
    t_redundant();
    t_blocked();
    t_release();
    t_priority();
    t_disable();
    finish_run();
  end

endmodule